// File: doc/BRIEF.md
# Channel Shutdown Retry Controller

This block sits beside one output channel of a smart high-side switch and decides what the channel does after it has been turned off for protection. It owns the gate enable of the channel. Software turns the channel on or off with a command write. Fast overcurrent and thermal fault inputs turn the channel off at once. A sustained-overcurrent comparator input turns it off only after it has stayed high for a selected delay. After a shutdown the channel either waits and retries or stays latched off until software writes the command again.

Each turn-on opens an inrush window of a selected length, and the inrush-active flag shows it. When capacitive-charge mode is selected, the sustained-overcurrent evaluation is held off for the whole window and starts only once it has ended. A shutdown caused by sustained overcurrent is followed by a cool-down of 0.8 s, 2.0 s or 4.0 s before the retry. Any other fault shutdown is followed by a fixed retry wait. A thermal shutdown also waits for the thermal input to fall.

All timing runs on a base tick input that pulses once every 100 µs. A timed phase of L ticks ends on the clock edge that follows the L-th tick counted inside that phase. Ticks arriving on the edge that enters a phase are not counted.

Top module: `chsd_top`

## Requirements
- R1: While reset is high and after it is released, gate_en, latched_off and inrush_active are all 0.
- R2: A command write with cmd_on=1 while the channel is off or latched raises gate_en on the next edge. It then holds inrush_active high for an inrush window set by cfg_inrush, with codes 0..7 giving 0, 2, 4, 6, 10, 20, 50 and 100 ms (ten ticks per ms). Code 0 goes straight to the on state and never raises inrush_active. A write of 1 while the channel is already driving has no effect.
- R3: A command write with cmd_on=0 turns the channel off on the next edge from any state. It clears latched_off and inrush_active, cancels every timer, and nothing turns the channel on again until a new write of 1.
- R4: While gate_en is 1, oc_flt=1 or ot_flt=1 drops gate_en on the next edge. While the gate is off, these inputs have no effect.
- R5: When cfg_latch=0, a channel shut down by oc_flt or ot_flt turns on again through a new inrush window after RETRY_TICKS ticks (default 10, i.e. 1 ms). After a thermal shutdown the retry waits further until ot_flt is 0.
- R6: When cfg_latch=1, any fault shutdown leaves the channel off with latched_off=1 until a command write. A write of 1 restarts the channel and clears latched_off.
- R7: When cfg_i2t_en=1 and the channel is being evaluated, sust_oc held high for the delay set by cfg_dly shuts the channel off. Codes 0..3 give 2, 4, 10 and 20 ticks (0.2, 0.4, 1.0, 2.0 ms). The delay count restarts from zero whenever sust_oc falls before the count expires.
- R8: After a sustained-overcurrent shutdown, cfg_cool codes 1..3 hold the channel off for 8000, 20000 or 40000 ticks (0.8, 2.0, 4.0 s) and then retry. Code 0, or cfg_latch=1, latches the channel off instead.
- R9: With cfg_cap_mode=1, sust_oc is not evaluated while inrush_active is high, and evaluation begins when the window ends. With cfg_cap_mode=0, it is evaluated during the window too.
- R10: The timers advance only on clock edges where tick=1. With tick held at 0, a retry wait never ends.
- R11: With cfg_i2t_en=0, sust_oc never shuts the channel off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse every 100 µs |
| cmd_wr | input | 1 | Strobe for a write of the channel-on command |
| cmd_on | input | 1 | Value written to the channel-on command |
| oc_flt | input | 1 | Immediate overcurrent fault |
| ot_flt | input | 1 | Thermal shutdown fault |
| sust_oc | input | 1 | Current is above the delayed turn-off threshold |
| cfg_i2t_en | input | 1 | Enables sustained-overcurrent evaluation |
| cfg_latch | input | 1 | 1 latches off after a fault, 0 auto-retries |
| cfg_cap_mode | input | 1 | Capacitive-charge mode |
| cfg_dly | input | 2 | Sustained-overcurrent delay code |
| cfg_cool | input | 2 | Cool-down code after a sustained-overcurrent shutdown |
| cfg_inrush | input | 3 | Inrush window code |
| gate_en | output | 1 | Gate drive enable |
| latched_off | output | 1 | Channel is latched off |
| inrush_active | output | 1 | Inrush window running |

## Verification
The assertions assume that a command write and a fault never fight in a way the priority does not cover: a write of 0 always wins. They also assume that configuration inputs are held steady while a timed phase is running, and that fault inputs are single-bit levels already synchronized to clk. The stimulus changes configuration only while the channel is off or settled in the on state. It drives every input on the falling edge and pulses oc_flt for one cycle, so each expected edge follows from a single cause. Thermal faults are held as a level, which exercises the wait for the thermal input to clear.

// File: rtl/chsd_pkg.sv
package chsd_pkg;

    // Longest cool-down expressed in 100 us ticks
    localparam int unsigned COOL_MAX_TICKS = 40000;

    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_INRUSH = 3'd1,
        ST_ON     = 3'd2,
        ST_RETRY  = 3'd3,
        ST_COOL   = 3'd4,
        ST_LATCH  = 3'd5
    } chsd_state_e;

    typedef struct packed {
        logic       i2t_en;
        logic       latch;
        logic       cap_mode;
        logic [1:0] dly;
        logic [1:0] cool;
        logic [2:0] inrush;
    } chsd_cfg_t;

    // Sustained-overcurrent delay: 0.2, 0.4, 1.0, 2.0 ms
    function automatic int unsigned delay_ticks(logic [1:0] code);
        case (code)
            2'd0:    return 2;
            2'd1:    return 4;
            2'd2:    return 10;
            default: return 20;
        endcase
    endfunction

    // Inrush window: 0, 2, 4, 6, 10, 20, 50, 100 ms
    function automatic int unsigned inrush_ticks(logic [2:0] code);
        case (code)
            3'd0:    return 0;
            3'd1:    return 20;
            3'd2:    return 40;
            3'd3:    return 60;
            3'd4:    return 100;
            3'd5:    return 200;
            3'd6:    return 500;
            default: return 1000;
        endcase
    endfunction

    // Cool-down: code 0 means no retry; then 0.8, 2.0, 4.0 s
    function automatic int unsigned cooldown_ticks(logic [1:0] code);
        case (code)
            2'd0:    return 0;
            2'd1:    return 8000;
            2'd2:    return 20000;
            default: return COOL_MAX_TICKS;
        endcase
    endfunction

endpackage

// File: rtl/chsd_tick_counter.sv
module chsd_tick_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         reached
);
    logic [W-1:0] cnt;

    // Saturates once the limit is met so the flag stays level
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (tick && !reached) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign reached = (cnt >= limit);
endmodule

// File: rtl/chsd_fsm.sv
module chsd_fsm
    import chsd_pkg::*;
#(
    parameter int W           = 16,
    parameter int RETRY_TICKS = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_wr,
    input  logic        cmd_on,
    input  logic        oc_flt,
    input  logic        ot_flt,
    input  logic        sust_oc,
    input  chsd_cfg_t   cfg,
    input  logic        phase_done,
    input  logic        sust_done,
    output chsd_state_e state,
    output logic        phase_clr,
    output logic [W-1:0] phase_limit,
    output logic        sust_clr,
    output logic [W-1:0] sust_limit
);
    chsd_state_e nxt;
    chsd_state_e start_st;
    logic        driving;
    logic        sust_eval;
    logic        sust_hit;

    assign driving   = (state == ST_ON) || (state == ST_INRUSH);
    assign sust_eval = cfg.i2t_en &&
                       ((state == ST_ON) || ((state == ST_INRUSH) && !cfg.cap_mode));
    assign sust_hit  = sust_eval && sust_done;
    assign start_st  = (inrush_ticks(cfg.inrush) == 0) ? ST_ON : ST_INRUSH;

    always_comb begin
        nxt = state;
        if (cmd_wr && !cmd_on) begin
            nxt = ST_OFF;
        end else begin
            case (state)
                ST_OFF, ST_LATCH: begin
                    if (cmd_wr) nxt = start_st;
                end
                ST_INRUSH, ST_ON: begin
                    if (oc_flt || ot_flt) begin
                        nxt = cfg.latch ? ST_LATCH : ST_RETRY;
                    end else if (sust_hit) begin
                        nxt = (cfg.latch || (cfg.cool == 2'd0)) ? ST_LATCH : ST_COOL;
                    end else if ((state == ST_INRUSH) && phase_done) begin
                        nxt = ST_ON;
                    end
                end
                ST_RETRY: begin
                    if (phase_done && !ot_flt) nxt = start_st;
                end
                ST_COOL: begin
                    if (phase_done) nxt = start_st;
                end
                default: nxt = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_OFF;
        else     state <= nxt;
    end

    always_comb begin
        case (state)
            ST_INRUSH: phase_limit = W'(inrush_ticks(cfg.inrush));
            ST_COOL:   phase_limit = W'(cooldown_ticks(cfg.cool));
            ST_RETRY:  phase_limit = W'(RETRY_TICKS);
            default:   phase_limit = '0;
        endcase
    end

    assign phase_clr  = (nxt != state) || !driving && (state != ST_RETRY) && (state != ST_COOL);
    assign sust_clr   = !(sust_eval && sust_oc);
    assign sust_limit = W'(delay_ticks(cfg.dly));
endmodule

// File: rtl/chsd_top.sv
module chsd_top
    import chsd_pkg::*;
#(
    parameter int RETRY_TICKS = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       cmd_wr,
    input  logic       cmd_on,
    input  logic       oc_flt,
    input  logic       ot_flt,
    input  logic       sust_oc,
    input  logic       cfg_i2t_en,
    input  logic       cfg_latch,
    input  logic       cfg_cap_mode,
    input  logic [1:0] cfg_dly,
    input  logic [1:0] cfg_cool,
    input  logic [2:0] cfg_inrush,
    output logic       gate_en,
    output logic       latched_off,
    output logic       inrush_active
);
    localparam int unsigned MAX_TICKS =
        (RETRY_TICKS > COOL_MAX_TICKS) ? RETRY_TICKS : COOL_MAX_TICKS;
    localparam int W = $clog2(MAX_TICKS + 1);

    chsd_cfg_t   cfg;
    chsd_state_e state;
    logic        phase_clr, phase_done;
    logic        sust_clr, sust_done;
    logic [W-1:0] phase_limit, sust_limit;

    always_comb begin
        cfg.i2t_en   = cfg_i2t_en;
        cfg.latch    = cfg_latch;
        cfg.cap_mode = cfg_cap_mode;
        cfg.dly      = cfg_dly;
        cfg.cool     = cfg_cool;
        cfg.inrush   = cfg_inrush;
    end

    chsd_fsm #(.W(W), .RETRY_TICKS(RETRY_TICKS)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .cmd_wr      (cmd_wr),
        .cmd_on      (cmd_on),
        .oc_flt      (oc_flt),
        .ot_flt      (ot_flt),
        .sust_oc     (sust_oc),
        .cfg         (cfg),
        .phase_done  (phase_done),
        .sust_done   (sust_done),
        .state       (state),
        .phase_clr   (phase_clr),
        .phase_limit (phase_limit),
        .sust_clr    (sust_clr),
        .sust_limit  (sust_limit)
    );

    // Phase timer: inrush window, retry wait, cool-down
    chsd_tick_counter #(.W(W)) u_phase_tmr (
        .clk     (clk),
        .rst     (rst),
        .clr     (phase_clr),
        .tick    (tick),
        .limit   (phase_limit),
        .reached (phase_done)
    );

    // Sustained-overcurrent delay timer
    chsd_tick_counter #(.W(W)) u_sust_tmr (
        .clk     (clk),
        .rst     (rst),
        .clr     (sust_clr),
        .tick    (tick),
        .limit   (sust_limit),
        .reached (sust_done)
    );

    assign gate_en       = (state == ST_ON) || (state == ST_INRUSH);
    assign latched_off   = (state == ST_LATCH);
    assign inrush_active = (state == ST_INRUSH);
endmodule

// File: rtl/chsd_checker.sv
module chsd_checker (
    input logic clk,
    input logic rst,
    input logic cmd_wr,
    input logic cmd_on,
    input logic oc_flt,
    input logic ot_flt,
    input logic gate_en,
    input logic latched_off,
    input logic inrush_active
);
    assert_off_on_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !cmd_on) |=> (!gate_en && !latched_off && !inrush_active));

    assert_fault_cut_R4: assert property (@(posedge clk) disable iff (rst)
        (gate_en && (oc_flt || ot_flt) && !cmd_wr) |=> !gate_en);

    assert_latch_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (latched_off && !cmd_wr) |=> latched_off);

    assert_latch_release_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(latched_off) |-> $past(cmd_wr));

    assert_inrush_drives_R2: assert property (@(posedge clk) disable iff (rst)
        inrush_active |-> gate_en);

    assert_latch_gate_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(latched_off) |-> $past(gate_en));
endmodule

bind chsd_top chsd_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .cmd_wr        (cmd_wr),
    .cmd_on        (cmd_on),
    .oc_flt        (oc_flt),
    .ot_flt        (ot_flt),
    .gate_en       (gate_en),
    .latched_off   (latched_off),
    .inrush_active (inrush_active)
);

// File: tb/tb_chsd_top.sv
module tb_chsd_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b1;
    logic cmd_wr = 1'b0, cmd_on = 1'b0;
    logic oc_flt = 1'b0, ot_flt = 1'b0, sust_oc = 1'b0;
    logic cfg_i2t_en = 1'b0, cfg_latch = 1'b0, cfg_cap_mode = 1'b0;
    logic [1:0] cfg_dly = 2'd0, cfg_cool = 2'd0;
    logic [2:0] cfg_inrush = 3'd0;
    logic gate_en, latched_off, inrush_active;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    typedef struct {
        logic  g;
        logic  l;
        logic  i;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    chsd_top dut (
        .clk(clk), .rst(rst), .tick(tick), .cmd_wr(cmd_wr), .cmd_on(cmd_on),
        .oc_flt(oc_flt), .ot_flt(ot_flt), .sust_oc(sust_oc),
        .cfg_i2t_en(cfg_i2t_en), .cfg_latch(cfg_latch), .cfg_cap_mode(cfg_cap_mode),
        .cfg_dly(cfg_dly), .cfg_cool(cfg_cool), .cfg_inrush(cfg_inrush),
        .gate_en(gate_en), .latched_off(latched_off), .inrush_active(inrush_active)
    );

    // Driver side: queue the expected outputs for this falling edge
    task automatic expect_out(input logic g, input logic l, input logic i, input string tag);
        exp_q.push_back('{g, l, i, tag});
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cmd(input logic v);
        cmd_wr = 1'b1;
        cmd_on = v;
        step(1);
        cmd_wr = 1'b0;
    endtask

    task automatic pulse_oc();
        oc_flt = 1'b1;
        step(1);
        oc_flt = 1'b0;
    endtask

    // Monitor: compare everything queued for this falling edge
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #2;
            while (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                n_checks++;
                if ({gate_en, latched_off, inrush_active} !== {e.g, e.l, e.i}) begin
                    n_fail++;
                    $display("FAIL %s: gate/latched/inrush = %b%b%b, expected %b%b%b",
                             e.tag, gate_en, latched_off, inrush_active, e.g, e.l, e.i);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: run did not finish, actual hung, expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step(3);
        expect_out(0, 0, 0, "R1 in reset");
        rst = 1'b0;
        step(2);
        expect_out(0, 0, 0, "R1 after reset");

        // R2: inrush window code 1 = 20 ticks
        cfg_inrush = 3'd1;
        write_cmd(1'b1);
        expect_out(1, 0, 1, "R2 window starts");
        step(20);
        expect_out(1, 0, 1, "R2 window last cycle");
        step(1);
        expect_out(1, 0, 0, "R2 window ended");
        write_cmd(1'b1);
        expect_out(1, 0, 0, "R2 rewrite while on ignored");

        // R3: clear cancels inrush
        write_cmd(1'b0);
        expect_out(0, 0, 0, "R3 off from on");
        cfg_inrush = 3'd2;
        write_cmd(1'b1);
        step(5);
        expect_out(1, 0, 1, "R2 window code 2 running");
        write_cmd(1'b0);
        expect_out(0, 0, 0, "R3 cancel inrush");
        step(50);
        expect_out(0, 0, 0, "R3 stays off");

        // R2: code 0 skips window
        cfg_inrush = 3'd0;
        write_cmd(1'b1);
        expect_out(1, 0, 0, "R2 zero window");

        // R4/R5: overcurrent auto-retry after 10 ticks
        pulse_oc();
        expect_out(0, 0, 0, "R4 oc cut");
        step(10);
        expect_out(0, 0, 0, "R5 retry still waiting");
        step(1);
        expect_out(1, 0, 0, "R5 retry turned on");

        // R4/R5: thermal waits for fault to clear
        ot_flt = 1'b1;
        step(1);
        expect_out(0, 0, 0, "R4 thermal cut");
        step(19);
        expect_out(0, 0, 0, "R5 thermal hold");
        ot_flt = 1'b0;
        step(1);
        expect_out(1, 0, 0, "R5 thermal release");

        // R6: latch mode
        cfg_latch = 1'b1;
        pulse_oc();
        expect_out(0, 1, 0, "R6 latched");
        step(60);
        expect_out(0, 1, 0, "R6 stays latched");
        write_cmd(1'b1);
        expect_out(1, 0, 0, "R6 rewrite restarts");
        pulse_oc();
        expect_out(0, 1, 0, "R6 latched again");
        write_cmd(1'b0);
        expect_out(0, 0, 0, "R3 off clears latch");
        cfg_latch = 1'b0;
        write_cmd(1'b1);

        // R7: sustained overcurrent, code 1 = 4 ticks, with a dip
        cfg_i2t_en = 1'b1;
        cfg_dly    = 2'd1;
        cfg_cool   = 2'd1;
        sust_oc = 1'b1;
        step(3);
        sust_oc = 1'b0;
        step(1);
        sust_oc = 1'b1;
        step(2);
        expect_out(1, 0, 0, "R7 delay restarts after dip");
        step(2);
        expect_out(1, 0, 0, "R7 before expiry");
        step(1);
        expect_out(0, 0, 0, "R7 sustained trip");
        sust_oc = 1'b0;

        // R8: cool-down code 1 = 8000 ticks
        step(8000);
        expect_out(0, 0, 0, "R8 cooling code 1");
        step(1);
        expect_out(1, 0, 0, "R8 cool code 1 expired");

        // R8: code 0 latches
        cfg_cool = 2'd0;
        cfg_dly  = 2'd0;
        sust_oc = 1'b1;
        step(3);
        expect_out(0, 1, 0, "R8 cool code 0 latches");
        sust_oc = 1'b0;
        write_cmd(1'b1);
        expect_out(1, 0, 0, "R6 relaunch after latch");

        // R8: code 2 = 20000 ticks
        cfg_cool = 2'd2;
        sust_oc = 1'b1;
        step(3);
        sust_oc = 1'b0;
        expect_out(0, 0, 0, "R8 trip code 2");
        step(20000);
        expect_out(0, 0, 0, "R8 cooling code 2");
        step(1);
        expect_out(1, 0, 0, "R8 cool code 2 expired");

        // R3: cancel during cool-down code 3
        cfg_cool = 2'd3;
        sust_oc = 1'b1;
        step(3);
        sust_oc = 1'b0;
        step(100);
        expect_out(0, 0, 0, "R8 cooling code 3");
        write_cmd(1'b0);
        expect_out(0, 0, 0, "R3 cancel cool-down");
        step(40100);
        expect_out(0, 0, 0, "R3 no restart after cancel");

        // R9: capacitive-charge mode suppresses evaluation in window
        cfg_latch    = 1'b1;
        cfg_inrush   = 3'd1;
        cfg_cap_mode = 1'b1;
        sust_oc      = 1'b1;
        write_cmd(1'b1);
        expect_out(1, 0, 1, "R9 window starts");
        step(20);
        expect_out(1, 0, 1, "R9 no trip in window");
        step(9);
        expect_out(0, 1, 0, "R9 trips after window");
        sust_oc = 1'b0;
        write_cmd(1'b0);
        cfg_cap_mode = 1'b0;
        sust_oc = 1'b1;
        write_cmd(1'b1);
        expect_out(1, 0, 1, "R9 window starts normal mode");
        step(3);
        expect_out(0, 1, 0, "R9 trips inside window without cap mode");
        sust_oc = 1'b0;
        write_cmd(1'b0);
        cfg_latch = 1'b0;

        // R11: evaluation disabled
        cfg_i2t_en = 1'b0;
        cfg_inrush = 3'd0;
        sust_oc = 1'b1;
        write_cmd(1'b1);
        step(100);
        expect_out(1, 0, 0, "R11 comparator ignored");
        sust_oc = 1'b0;

        // R10: timers frozen without tick
        tick = 1'b0;
        pulse_oc();
        expect_out(0, 0, 0, "R4 oc cut before freeze");
        step(50);
        expect_out(0, 0, 0, "R10 retry frozen without tick");
        tick = 1'b1;
        step(10);
        expect_out(0, 0, 0, "R10 retry counting again");
        step(1);
        expect_out(1, 0, 0, "R10 retry resumes");

        step(3);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule